// File: doc/BRIEF.md
# Block-Granular DMA Channel

This block is one DMA channel. Software sets it up through a small register window, and it moves half-word data between an internal FIFO and a memory master port. The FIFO is the peripheral side of the channel: a peripheral, or software acting for one, pushes half-words into it or pops half-words out of it through a data register. The engine moves data in whole blocks only. A block is 64 bytes, which is 32 half-word beats at consecutive addresses.

A block counter sets the length of a job. After every block the current address moves forward by one block and the counter drops by one. When the counter runs out, the channel either stops or starts the job again from the stored start address and count. It can raise an interrupt when the counter runs out. If the job is about to step into a new 512 KiB address region, the channel stops and flags an error. A status read returns the FIFO fill level together with the error and pending flags.

Top module: `blkdma_channel`

## Requirements
- R1: After reset, the mode register reads 0x0000_0400 (empty flag only). The start address, current address, block count and diagnostic registers read zero, and `irq` is low.
- R2: Register offsets are: start address 0x000, diagnostic 0x100, FIFO data 0x202, mode 0x300, block count 0x402, current address 0x500. A write to the start address forces bits 5:0 to zero and copies the value into the current address. A write to the block count stores bits 15:0 both as the live count and as the reload value.
- R3: The mode register holds enable on bit 30, auto-restart on bit 29, interrupt enable on bit 28 and direction on bit 27 (1 = FIFO to memory, 0 = memory to FIFO). A mode read returns those four bits together with FIFO full on bit 11, FIFO empty on bit 10, error on bit 9, interrupt pending on bit 8 and the FIFO level on bits 7:0. Bits 31 and 26 always read as zero.
- R4: In the FIFO-to-memory direction, a write to the data register pushes bits 15:0 into the 32-entry FIFO. A push into a full FIFO is dropped. In the memory-to-FIFO direction, a data register write has no effect.
- R5: Writing 1 to mode bit 31 empties the FIFO.
- R6: In the FIFO-to-memory direction, a burst starts only once at least 32 half-words are held. It then writes 32 half-words in FIFO order to current address + 2·k, for k = 0..31.
- R7: In the memory-to-FIFO direction, a burst starts only once at least 32 entries are free. It then reads current address + 2·k, for k = 0..31, into the FIFO, and data register reads pop those values in order.
- R8: After every block that is not the last, the current address grows by 64 and the block count drops by one.
- R9: When the last block completes and auto-restart is clear, the count reads zero, the current address has grown by 64, the enable bit clears, and no further memory requests occur.
- R10: When the last block completes and auto-restart is set, the current address reloads from the start address, the count reloads from its last written value, the enable bit stays set, and transfers carry on.
- R11: The interrupt-pending flag sets at the end of the last block only if interrupt enable is set. Any mode write clears it. `irq` follows the flag.
- R12: Suppose a block completes, blocks remain, and the next address would lie in a different 512 KiB region. The channel then advances the address and count, sets the error flag, clears enable and issues no further requests. Writing 1 to mode bit 26 clears the error.
- R13: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on a data register read) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Byte address of the half-word beat |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Beat accepted / read data valid |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| irq | output | 1 | Interrupt-pending flag |

## Verification
The hardest state to reach from the ports is the 512 KiB boundary stop. It needs a real block finishing on the last 64-byte slot of a region while count remains. The stimulus loads the start address 0x7FFC0 with a count of two and fills the FIFO with one full block. It then checks the error flag, the cleared enable and the advanced address, and shows that a second full block does not trigger any request. Auto-restart is reached in the memory-to-FIFO direction by draining the FIFO through data reads. This makes the reloaded channel fetch the same block again.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
   // register byte offsets inside the channel window
   localparam logic [11:0] OFS_START = 12'h000;
   localparam logic [11:0] OFS_DIAG  = 12'h100;
   localparam logic [11:0] OFS_DATA  = 12'h202;
   localparam logic [11:0] OFS_MODE  = 12'h300;
   localparam logic [11:0] OFS_COUNT = 12'h402;
   localparam logic [11:0] OFS_CUR   = 12'h500;

   // mode register control bits
   localparam int MB_FLUSH  = 31;
   localparam int MB_EN     = 30;
   localparam int MB_AUTO   = 29;
   localparam int MB_IE     = 28;
   localparam int MB_DIR    = 27;
   localparam int MB_CLRERR = 26;

   // mode register status bits
   localparam int SB_FULL   = 11;
   localparam int SB_EMPTY  = 10;
   localparam int SB_ERR    = 9;
   localparam int SB_PEND   = 8;

   typedef enum logic {ENG_IDLE, ENG_BURST} eng_state_e;
endpackage

// File: rtl/blkdma_fifo.sv
module blkdma_fifo #(
   parameter int DEPTH  = 32,
   parameter int WIDTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [LVL_W-1:0] level
);
   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign do_push = push && (level != LVL_W'(DEPTH));
   assign do_pop  = pop  && (level != '0);
   assign rdata   = store[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push && !flush) store[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
   import blkdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BLK_HW = 32,
   localparam int BEAT_W = $clog2(BLK_HW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              dir_in,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [15:0]       fifo_head,
   input  logic              mem_ack,
   input  logic [15:0]       mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   output logic              fifo_pop,
   output logic              fifo_push,
   output logic [15:0]       fifo_push_data,
   output logic              blk_done,
   output logic              busy,
   output logic [BEAT_W-1:0] beat_idx
);
   eng_state_e        state;
   logic [BEAT_W-1:0] beat;
   logic              dir_q;
   logic              beat_ok, last_beat;

   assign busy           = (state == ENG_BURST);
   assign mem_req        = busy;
   assign mem_we         = dir_q;
   assign mem_addr       = base_addr + ADDR_W'({beat, 1'b0});
   assign mem_wdata      = fifo_head;
   assign beat_ok        = mem_req && mem_ack;
   assign last_beat      = (beat == BEAT_W'(BLK_HW - 1));
   assign fifo_pop       = beat_ok && dir_q;
   assign fifo_push      = beat_ok && !dir_q;
   assign fifo_push_data = mem_rdata;
   assign blk_done       = beat_ok && last_beat;
   assign beat_idx       = beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ENG_IDLE;
         beat  <= '0;
         dir_q <= 1'b0;
      end else if (state == ENG_IDLE) begin
         if (go) begin
            state <= ENG_BURST;
            beat  <= '0;
            dir_q <= dir_in;
         end
      end else if (beat_ok) begin
         beat <= beat + 1'b1;
         if (last_beat) state <= ENG_IDLE;
      end
   end
endmodule

// File: rtl/blkdma_regs.sv
module blkdma_regs
   import blkdma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 16,
   parameter int FIFO_DEPTH  = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int BOUND_LOG2  = 19,
   localparam int BLK_HW     = BLOCK_BYTES / 2,
   localparam int BEAT_W     = $clog2(BLK_HW),
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [15:0]       fifo_head,
   input  logic              eng_busy,
   input  logic [BEAT_W-1:0] eng_beat,
   input  logic              blk_done,
   output logic              bus_push,
   output logic              bus_pop,
   output logic              flush,
   output logic              go,
   output logic              dir_q,
   output logic [ADDR_W-1:0] cur_q,
   output logic              err_q,
   output logic              ie_q,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_BYTES - 1);

   logic [ADDR_W-1:0] start_q, cur_adv;
   logic [CNT_W-1:0]  cnt_q, reload_q, cnt_dec;
   logic              en_q, auto_q, pend_q;
   logic              hit_start, hit_diag, hit_data, hit_mode, hit_count, hit_cur;
   logic              wr_mode, last_blk, crosses, room_ok;
   logic [LVL_W-1:0]  free_slots;

   assign hit_start = (reg_addr == OFS_START);
   assign hit_diag  = (reg_addr == OFS_DIAG);
   assign hit_data  = (reg_addr == OFS_DATA);
   assign hit_mode  = (reg_addr == OFS_MODE);
   assign hit_count = (reg_addr == OFS_COUNT);
   assign hit_cur   = (reg_addr == OFS_CUR);

   assign wr_mode  = reg_wr && hit_mode;
   assign flush    = wr_mode && reg_wdata[MB_FLUSH];
   assign bus_push = reg_wr && hit_data && dir_q;
   assign bus_pop  = reg_rd && hit_data && !dir_q;
   assign irq      = pend_q;

   assign cur_adv  = cur_q + ADDR_W'(BLOCK_BYTES);
   assign cnt_dec  = cnt_q - 1'b1;
   assign last_blk = (cnt_dec == '0);
   assign crosses  = (cur_adv[ADDR_W-1:BOUND_LOG2] != cur_q[ADDR_W-1:BOUND_LOG2]);

   assign free_slots = LVL_W'(FIFO_DEPTH) - fifo_level;
   assign room_ok    = dir_q ? (fifo_level >= LVL_W'(BLK_HW))
                             : (free_slots >= LVL_W'(BLK_HW));
   assign go = en_q && !err_q && (cnt_q != '0) && !eng_busy && !blk_done && room_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= '0;
         cur_q    <= '0;
         cnt_q    <= '0;
         reload_q <= '0;
         en_q     <= 1'b0;
         auto_q   <= 1'b0;
         ie_q     <= 1'b0;
         dir_q    <= 1'b0;
         err_q    <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         if (reg_wr && hit_start) begin
            start_q <= reg_wdata[ADDR_W-1:0] & ALIGN_MASK;
            cur_q   <= reg_wdata[ADDR_W-1:0] & ALIGN_MASK;
         end
         if (reg_wr && hit_count) begin
            cnt_q    <= reg_wdata[CNT_W-1:0];
            reload_q <= reg_wdata[CNT_W-1:0];
         end
         if (wr_mode) begin
            en_q   <= reg_wdata[MB_EN];
            auto_q <= reg_wdata[MB_AUTO];
            ie_q   <= reg_wdata[MB_IE];
            dir_q  <= reg_wdata[MB_DIR];
            pend_q <= 1'b0;
            if (reg_wdata[MB_CLRERR]) err_q <= 1'b0;
         end
         if (blk_done) begin
            if (last_blk) begin
               if (ie_q) pend_q <= 1'b1;
               if (auto_q) begin
                  cur_q <= start_q;
                  cnt_q <= reload_q;
               end else begin
                  cur_q <= cur_adv;
                  cnt_q <= '0;
                  en_q  <= 1'b0;
               end
            end else begin
               cur_q <= cur_adv;
               cnt_q <= cnt_dec;
               if (crosses) begin
                  err_q <= 1'b1;
                  en_q  <= 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_start)      reg_rdata = 32'(start_q);
      else if (hit_diag)  reg_rdata = (32'(eng_busy) << 8) | 32'(eng_beat);
      else if (hit_data)  reg_rdata = {16'h0000, fifo_head};
      else if (hit_count) reg_rdata = 32'(cnt_q);
      else if (hit_cur)   reg_rdata = 32'(cur_q);
      else if (hit_mode) begin
         reg_rdata[MB_EN]    = en_q;
         reg_rdata[MB_AUTO]  = auto_q;
         reg_rdata[MB_IE]    = ie_q;
         reg_rdata[MB_DIR]   = dir_q;
         reg_rdata[SB_FULL]  = (fifo_level == LVL_W'(FIFO_DEPTH));
         reg_rdata[SB_EMPTY] = (fifo_level == '0);
         reg_rdata[SB_ERR]   = err_q;
         reg_rdata[SB_PEND]  = pend_q;
         reg_rdata[7:0]      = 8'(fifo_level);
      end
   end
endmodule

// File: rtl/blkdma_channel.sv
module blkdma_channel #(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 16,
   parameter int FIFO_DEPTH  = 32,
   parameter int BLOCK_BYTES = 64,
   parameter int BOUND_LOG2  = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [15:0]       mem_rdata,
   output logic              irq
);
   localparam int BLK_HW = BLOCK_BYTES / 2;
   localparam int BEAT_W = $clog2(BLK_HW);
   localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < BLK_HW) begin : g_chk_depth
      $error("FIFO must hold at least one block");
   end
   if ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0 || BLOCK_BYTES < 4) begin : g_chk_blk
      $error("block size must be a power of two of at least 4 bytes");
   end
   if (BOUND_LOG2 <= $clog2(BLOCK_BYTES) || BOUND_LOG2 >= ADDR_W) begin : g_chk_bound
      $error("boundary must lie between block size and address width");
   end
   if (LVL_W > 8 || ADDR_W > 32 || CNT_W > 32) begin : g_chk_width
      $error("level, address or count too wide for the register window");
   end

   logic [LVL_W-1:0]  fifo_level;
   logic [15:0]       fifo_head, eng_push_data;
   logic              eng_pop, eng_push, bus_push, bus_pop, flush;
   logic              go, dir_q, err_q, ie_q, blk_done, eng_busy;
   logic [ADDR_W-1:0] cur_q;
   logic [BEAT_W-1:0] eng_beat;

   blkdma_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH),
      .BLOCK_BYTES(BLOCK_BYTES), .BOUND_LOG2(BOUND_LOG2)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fifo_level(fifo_level), .fifo_head(fifo_head), .eng_busy(eng_busy),
      .eng_beat(eng_beat), .blk_done(blk_done), .bus_push(bus_push),
      .bus_pop(bus_pop), .flush(flush), .go(go), .dir_q(dir_q),
      .cur_q(cur_q), .err_q(err_q), .ie_q(ie_q), .irq(irq)
   );

   blkdma_engine #(.ADDR_W(ADDR_W), .BLK_HW(BLK_HW)) u_engine (
      .clk(clk), .rst_n(rst_n), .go(go), .dir_in(dir_q), .base_addr(cur_q),
      .fifo_head(fifo_head), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .fifo_pop(eng_pop), .fifo_push(eng_push),
      .fifo_push_data(eng_push_data), .blk_done(blk_done), .busy(eng_busy),
      .beat_idx(eng_beat)
   );

   blkdma_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(16)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(eng_push || bus_push),
      .wdata(eng_push ? eng_push_data : reg_wdata[15:0]),
      .pop(eng_pop || bus_pop), .rdata(fifo_head), .level(fifo_level)
   );
endmodule

// File: rtl/blkdma_checker.sv
module blkdma_checker #(
   parameter int ADDR_W     = 32,
   parameter int FIFO_DEPTH = 32,
   parameter int BLK_HW     = 32,
   parameter int LVL_W      = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              irq,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              err_q,
   input logic              ie_q
);
   p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   p_level_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_level) <= FIFO_DEPTH);

   p_no_start_in_error_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> !$past(err_q));

   p_irq_needs_ie_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ie_q));

   p_write_burst_full_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) && mem_we |-> int'(fifo_level) >= BLK_HW);

   p_read_burst_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) && !mem_we |-> int'(fifo_level) + BLK_HW <= FIFO_DEPTH);
endmodule

bind blkdma_channel blkdma_checker #(
   .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .BLK_HW(BLK_HW), .LVL_W(LVL_W)
) u_checker (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
   .mem_we(mem_we), .mem_addr(mem_addr), .irq(irq),
   .fifo_level(fifo_level), .err_q(err_q), .ie_q(ie_q)
);

// File: tb/test_blkdma_channel.sv
module test_blkdma_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, irq;
   logic [31:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;

   int n_chk = 0, n_bad = 0;
   int beat_cnt = 0, wr_cnt = 0, viol = 0;
   logic [31:0] wr_addr [256];
   logic [15:0] wr_data [256];
   logic        pend_prev = 1'b0;
   logic [31:0] addr_prev = '0;

   always #10 clk = ~clk;

   blkdma_channel i_blkdma_channel (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .irq(irq)
   );

   function automatic logic [15:0] mem_model(input logic [31:0] a);
      return a[16:1] ^ 16'h5A3C;
   endfunction

   // memory responder: one-cycle-late acknowledge, logs every beat
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         pend_prev <= 1'b0;
      end else begin
         if (pend_prev && (!mem_req || mem_addr != addr_prev)) viol <= viol + 1;
         pend_prev <= mem_req && !mem_ack;
         addr_prev <= mem_addr;
         mem_ack   <= mem_req && !mem_ack;
         mem_rdata <= mem_model(mem_addr);
         if (mem_req && mem_ack) begin
            beat_cnt <= beat_cnt + 1;
            if (mem_we && wr_cnt < 256) begin
               wr_addr[wr_cnt] <= mem_addr;
               wr_data[wr_cnt] <= mem_wdata;
               wr_cnt <= wr_cnt + 1;
            end
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic wait_beats(input int n);
      for (int i = 0; i < 4000 && beat_cnt < n; i++) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   task automatic push_block(input logic [15:0] base);
      for (int k = 0; k < 32; k++) wr(12'h202, 32'(base + 16'(k)));
   endtask

   task automatic t_reset;
      expect_reg("R1 mode", 12'h300, 32'h0000_0400);
      expect_reg("R1 start", 12'h000, 32'h0);
      expect_reg("R1 cur", 12'h500, 32'h0);
      expect_reg("R1 count", 12'h402, 32'h0);
      expect_reg("R1 diag", 12'h100, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
   endtask

   task automatic t_regs;
      wr(12'h000, 32'h1234_5678);
      expect_reg("R2 start aligned", 12'h000, 32'h1234_5640);
      expect_reg("R2 cur copy", 12'h500, 32'h1234_5640);
      wr(12'h402, 32'hABCD_0003);
      expect_reg("R2 count", 12'h402, 32'h0000_0003);
   endtask

   task automatic t_fifo;
      wr(12'h300, 32'h0800_0000);
      expect_reg("R3 dir readback", 12'h300, 32'h0800_0400);
      for (int k = 0; k < 5; k++) wr(12'h202, 32'(k));
      expect_reg("R3 level 5", 12'h300, 32'h0800_0005);
      for (int k = 0; k < 28; k++) wr(12'h202, 32'(k));
      expect_reg("R4 full, extra push dropped", 12'h300, 32'h0800_0820);
      wr(12'h300, 32'h8800_0000);
      expect_reg("R5 flush", 12'h300, 32'h0800_0400);
      wr(12'h300, 32'h0000_0000);
      wr(12'h202, 32'h0000_BEEF);
      expect_reg("R4 write ignored in read dir", 12'h300, 32'h0000_0400);
   endtask

   task automatic t_write_dir;
      wr(12'h000, 32'h0000_1000);
      wr(12'h402, 32'h2);
      wr(12'h300, 32'h5800_0000);
      push_block(16'h0100);
      wait_beats(32);
      for (int k = 0; k < 32; k++) begin
         check("R6 write addr", wr_addr[k], 32'h1000 + 32'(2 * k));
         check("R6 write data", 32'(wr_data[k]), 32'h100 + 32'(k));
      end
      expect_reg("R8 cur after block", 12'h500, 32'h0000_1040);
      expect_reg("R8 count after block", 12'h402, 32'h1);
      check("R11 no irq mid job", 32'(irq), 32'h0);
      push_block(16'h0200);
      wait_beats(64);
      check("R6 second block addr", wr_addr[63], 32'h0000_107E);
      check("R6 second block data", 32'(wr_data[63]), 32'h0000_021F);
      expect_reg("R9 cur advanced", 12'h500, 32'h0000_1080);
      expect_reg("R9 count zero", 12'h402, 32'h0);
      check("R11 irq raised", 32'(irq), 32'h1);
      expect_reg("R9 enable cleared, pend set", 12'h300, 32'h1800_0500);
      wr(12'h300, 32'h1800_0000);
      check("R11 mode write clears irq", 32'(irq), 32'h0);
      push_block(16'h0300);
      repeat (100) @(posedge clk);
      check("R9 no request after stop", 32'(beat_cnt), 32'd64);
      expect_reg("R9 block left in fifo", 12'h300, 32'h1800_0820);
      wr(12'h300, 32'h8000_0000);
   endtask

   task automatic t_read_dir_auto;
      logic [31:0] v;
      wr(12'h000, 32'h0000_2000);
      wr(12'h402, 32'h1);
      wr(12'h300, 32'h6000_0000);
      wait_beats(96);
      expect_reg("R10 cur reloaded", 12'h500, 32'h0000_2000);
      expect_reg("R10 count reloaded", 12'h402, 32'h1);
      expect_reg("R10 enable kept, fifo full", 12'h300, 32'h6000_0820);
      check("R11 no irq without enable", 32'(irq), 32'h0);
      for (int k = 0; k < 32; k++) begin
         rd(12'h202, v);
         check("R7 popped data", v, 32'(mem_model(32'h2000 + 32'(2 * k))));
      end
      wait_beats(128);
      wr(12'h300, 32'h0000_0000);
      for (int k = 0; k < 32; k++) begin
         rd(12'h202, v);
         check("R10 refetched data", v, 32'(mem_model(32'h2000 + 32'(2 * k))));
      end
      repeat (50) @(posedge clk);
      check("R7 no fetch when disabled", 32'(beat_cnt), 32'd128);
   endtask

   task automatic t_boundary;
      wr(12'h000, 32'h0007_FFC0);
      wr(12'h402, 32'h2);
      wr(12'h300, 32'h4800_0000);
      push_block(16'h0400);
      wait_beats(160);
      check("R12 last block addr", wr_addr[95], 32'h0007_FFFE);
      expect_reg("R12 error set, enable cleared", 12'h300, 32'h0800_0600);
      expect_reg("R12 cur advanced", 12'h500, 32'h0008_0000);
      expect_reg("R12 count", 12'h402, 32'h1);
      push_block(16'h0500);
      repeat (100) @(posedge clk);
      check("R12 stopped", 32'(beat_cnt), 32'd160);
      wr(12'h300, 32'h0C00_0000);
      expect_reg("R12 error cleared", 12'h300, 32'h0800_0820);
      check("R13 request held until ack", 32'(viol), 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regs;
      t_fifo;
      t_write_dir;
      t_read_dir_auto;
      t_boundary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule